// File: doc/BRIEF.md
# Speaker and Status Control Port

This block is a byte-wide system control port whose write and read views carry different meanings. A processor write loads four enable flags (timer-2 gate, speaker data enable, memory parity-check enable, channel-check enable) and can also use its top bit as a one-shot command that clears the latched timer-0 interrupt request. The speaker signal is the live timer-2 output masked by the speaker enable. The two check enables leave the block as levels for the non-maskable interrupt logic.

A read returns a status byte. It holds the four stored enables, the live timer-2 output, and a flag that changes state once for every memory refresh request. The port watches the timer-0 output and latches each rising edge as a level interrupt request, which stays asserted until software clears it. Optional input synchroniser stages and the idle behaviour of the read bus are chosen by parameters.

Top module: `spkr_ctl_port`

## Requirements
- R1: After reset, tmr2_gate, spkr_out, irq0, par_chk_en and chan_chk_en are 0, and a read returns 0x00 while tmr2_out is 0.
- R2: A write (wr_en high at a rising clock edge) stores wr_data bits 3..0 from that edge onward. A read returns them in rd_data bits 3..0. Bit 2 drives par_chk_en and bit 3 drives chan_chk_en.
- R3: Write data bits 6..4 are reserved and change no output and no read bit.
- R4: tmr2_gate equals the stored write bit 0.
- R5: spkr_out equals tmr2_out AND the stored write bit 1, combinationally and without a clock delay.
- R6: When tmr0_out is sampled high at a rising edge after being sampled low at the edge before, irq0 is 1 after that edge. irq0 then holds until it is cleared or reset. A falling edge or a steady level does not set it.
- R7: A write whose bit 7 is 1 clears irq0 at that edge, and a write whose bit 7 is 0 leaves it alone. If a timer-0 rising edge is sampled at the same edge as the clearing write, irq0 stays 1.
- R8: Read bit 4 inverts once for each rising edge of refresh_req and keeps its value while refresh_req stays high or low.
- R9: While rd_en is high, rd_data bit 5 is the live tmr2_out and bits 7..6 are 0. While rd_en is low, rd_data is 0x00.
- R10: Without wr_en, the stored enables do not change, whatever wr_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read select for rd_data |
| wr_data | input | 8 | Write data byte |
| tmr2_out | input | 1 | Timer-2 output level |
| tmr0_out | input | 1 | Timer-0 output level |
| refresh_req | input | 1 | Memory refresh request pulse |
| tmr2_gate | output | 1 | Timer-2 gate enable |
| spkr_out | output | 1 | Speaker drive |
| irq0 | output | 1 | Latched timer interrupt request |
| par_chk_en | output | 1 | Parity-check enable to NMI logic |
| chan_chk_en | output | 1 | Channel-check enable to NMI logic |
| rd_data | output | 8 | Status byte |

## Verification
On every cycle the assertions check these properties: an idle strobe keeps the enable register steady, a write loads it, the interrupt latch sets, holds and clears in the right order, set wins over clear, the refresh flag flips exactly on detected edges, and the speaker never sounds without timer-2 high. Other behaviour shows up only in the bench's scenarios. These cover the bit positions of the status byte, the reserved write bits having no effect across all 256 write values, the clear-versus-set collision, and a refresh request held high for several cycles.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned CTL_W      = 4;
   localparam int unsigned WB_GATE    = 0;
   localparam int unsigned WB_SPK     = 1;
   localparam int unsigned WB_PAR     = 2;
   localparam int unsigned WB_CHAN    = 3;
   localparam int unsigned WB_IRQ_CLR = 7;
   localparam int unsigned RB_REF     = 4;
   localparam int unsigned RB_T2      = 5;

   typedef struct packed {
      logic chan_en;
      logic par_en;
      logic spk_en;
      logic gate_en;
   } ctl_t;
endpackage

// File: rtl/spkr_edge_det.sv
module spkr_edge_det #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic rise_o
);
   if (SYNC_STAGES > 4) begin : g_chk
      $error("spkr_edge_det: SYNC_STAGES above 4 is not supported");
   end

   logic [SYNC_STAGES:0] chain;
   logic                 prev_q;

   assign chain[0] = in_i;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[SYNC_STAGES];
   end

   assign rise_o = chain[SYNC_STAGES] & ~prev_q;

   p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/spkr_ctl_reg.sv
module spkr_ctl_reg #(
   parameter int unsigned CTL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [CTL_W-1:0] d_i,
   output logic [CTL_W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/spkr_irq_latch.sv
module spkr_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
   p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/spkr_ctl_port.sv
module spkr_ctl_port
   import spkr_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SYNC_STAGES    = 0,
   parameter bit          READ_ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tmr2_out,
   input  logic              tmr0_out,
   input  logic              refresh_req,
   output logic              tmr2_gate,
   output logic              spkr_out,
   output logic              irq0,
   output logic              par_chk_en,
   output logic              chan_chk_en,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned HI_W = DATA_W - RB_T2 - 1;

   if (DATA_W != BYTE_W) begin : g_chk_w
      $error("spkr_ctl_port: DATA_W must be 8");
   end

   ctl_t ctl_q;
   logic [CTL_W-1:0] ctl_bits;
   logic t0_rise, ref_rise, irq_clr, ref_tog_q;
   logic [DATA_W-1:0] status;

   spkr_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en),
      .d_i(wr_data[CTL_W-1:0]), .q_o(ctl_bits)
   );
   assign ctl_q = ctl_t'(ctl_bits);

   spkr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_t0_edge (
      .clk(clk), .rst_n(rst_n), .in_i(tmr0_out), .rise_o(t0_rise)
   );
   spkr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .in_i(refresh_req), .rise_o(ref_rise)
   );

   assign irq_clr = wr_en & wr_data[WB_IRQ_CLR];

   spkr_irq_latch u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(t0_rise), .clr_i(irq_clr), .q_o(irq0)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        ref_tog_q <= 1'b0;
      else if (ref_rise) ref_tog_q <= ~ref_tog_q;
   end

   assign tmr2_gate   = ctl_q.gate_en;
   assign spkr_out    = tmr2_out & ctl_q.spk_en;
   assign par_chk_en  = ctl_q.par_en;
   assign chan_chk_en = ctl_q.chan_en;

   assign status = {{HI_W{1'b0}}, tmr2_out, ref_tog_q, ctl_bits};

   if (READ_ZERO_IDLE) begin : g_rd_gated
      assign rd_data = rd_en ? status : '0;
   end else begin : g_rd_open
      logic unused_rd;
      assign unused_rd = rd_en;
      assign rd_data   = status;
   end

   p_tog_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_rise |=> (ref_tog_q != $past(ref_tog_q)));
   p_tog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_rise |=> $stable(ref_tog_q));
   p_spk_needs_t2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spkr_out |-> (tmr2_out && tmr2_gate == ctl_bits[WB_GATE]));
endmodule

// File: tb/sim_spkr_ctl_port.sv
module sim_spkr_ctl_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic tmr2_out = 1'b0, tmr0_out = 1'b0, refresh_req = 1'b0;
   logic tmr2_gate, spkr_out, irq0, par_chk_en, chan_chk_en;
   logic [7:0] rd_data;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   logic tog_m = 1'b0;

   always #10 clk = ~clk;

   spkr_ctl_port u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
      .tmr2_out(tmr2_out), .tmr0_out(tmr0_out), .refresh_req(refresh_req),
      .tmr2_gate(tmr2_gate), .spkr_out(spkr_out), .irq0(irq0),
      .par_chk_en(par_chk_en), .chan_chk_en(chan_chk_en), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = ~d;
   endtask

   task automatic pulse_t0();
      @(negedge clk); tmr0_out = 1'b1;
      @(negedge clk); tmr0_out = 1'b0;
   endtask

   task automatic pulse_ref();
      @(negedge clk); refresh_req = 1'b1;
      @(negedge clk); refresh_req = 1'b0;
      tog_m = ~tog_m;
   endtask

   task automatic check_read(input string tag, input logic [3:0] ctl);
      for (int t = 0; t < 2; t++) begin
         tmr2_out = t[0]; rd_en = 1'b1; #1;
         chk({tag, " R9 read"}, rd_data, {2'b00, t[0], tog_m, ctl});
         chk("R5 spkr", {7'd0, spkr_out}, {7'd0, t[0] & ctl[1]});
         rd_en = 1'b0; #1;
         chk("R9 idle read", rd_data, 8'h00);
      end
      tmr2_out = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      rd_en = 1'b1; #1;
      chk("R1 read", rd_data, 8'h00);
      chk("R1 outs", {3'd0, tmr2_gate, spkr_out, irq0, par_chk_en, chan_chk_en}, 8'h00);
      rd_en = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      // R2 R3 R4 R7: sweep every write value
      for (int d = 0; d < 256; d++) begin
         pulse_t0();
         chk("R6 set", {7'd0, irq0}, 8'h01);
         do_write(d[7:0]);
         chk("R7 clear", {7'd0, irq0}, {7'd0, ~d[7]});
         chk("R4 gate", {7'd0, tmr2_gate}, {7'd0, d[0]});
         chk("R2 enables", {6'd0, chan_chk_en, par_chk_en}, {6'd0, d[3], d[2]});
         check_read("R2 R3", d[3:0]);
         if (d % 16 == 5) pulse_ref();
      end

      // R10 no write strobe
      do_write(8'h06);
      for (int d = 0; d < 16; d++) begin
         @(negedge clk); wr_data = d[7:0] * 8'd17;
      end
      @(negedge clk);
      check_read("R10 hold", 4'h6);

      // R6 steady high and falling edge do not set
      do_write(8'h80);
      @(negedge clk); tmr0_out = 1'b1;
      @(negedge clk);
      do_write(8'h80);
      chk("R7 clear while high", {7'd0, irq0}, 8'h00);
      repeat (3) @(negedge clk);
      chk("R6 level no set", {7'd0, irq0}, 8'h00);
      tmr0_out = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6 fall no set", {7'd0, irq0}, 8'h00);

      // R7 collision: set wins
      @(negedge clk); tmr0_out = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
      @(negedge clk); tmr0_out = 1'b0; wr_en = 1'b0;
      chk("R7 set wins", {7'd0, irq0}, 8'h01);
      do_write(8'h00);
      chk("R7 bit7 low keeps", {7'd0, irq0}, 8'h01);

      // R8 held refresh flips once
      @(negedge clk); refresh_req = 1'b1;
      repeat (4) @(negedge clk);
      refresh_req = 1'b0; tog_m = ~tog_m;
      repeat (2) @(negedge clk);
      check_read("R8 held", 4'h0);
      for (int k = 0; k < 5; k++) pulse_ref();
      check_read("R8 pulses", 4'h0);

      // R1 reset again
      do_write(8'h0F);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; tog_m = 1'b0;
      chk("R1 rereset", {3'd0, tmr2_gate, spkr_out, irq0, par_chk_en, chan_chk_en}, 8'h00);
      check_read("R1 rereset", 4'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule